// File: doc/BRIEF.md
# Register-Direct Integer Instruction Executor

This block runs a small set of 32-bit two-operand integer instructions against its own file of eight registers. Instructions arrive one byte per cycle on a valid-qualified byte input. An instruction is a one-byte opcode, or a two-byte opcode that starts with 0x0f, followed by an operand-selector byte where the opcode needs one. The block decodes the selector, routes two register operands to a shared arithmetic unit, writes one or two registers, and updates sign, zero and overflow flags. Only register-to-register operand forms are accepted.

Every accepted instruction ends with a one-cycle `done` pulse. Every rejected encoding ends with a one-cycle `illegal` pulse and leaves registers and flags as they were. A separate load port writes operand values into the register file. A combinational read port shows any register, so the surrounding logic or a test can observe results.

Top module: `rdx_exec`

## Requirements
- R1: The selector byte splits into a mode field (bits 7:6), a register/sub-operation field (bits 5:3) and an operand field (bits 2:0). Only mode 3 is executed. Register numbers 0..7 name the eight registers, and 0 and 2 are the accumulator and its high-half partner.
- R2: Opcodes 0x01, 0x29, 0x21, 0x09 and 0x31 replace operand-register with operand-register add, subtract, AND, OR or XOR the field register. Add and subtract set SF and ZF from the 32-bit result and OF on signed overflow. The bitwise operations set SF and ZF and clear OF.
- R3: Opcode 0x39 forms operand minus field register. It sets SF, ZF and OF as subtract does and writes no register.
- R4: Opcode 0x89 copies the field register into the operand register. Opcode 0x87 swaps the two in one instruction. Neither changes the flags.
- R5: Bytes 0x40..0x47 increment and 0x48..0x4f decrement the register in bits 2:0, with no selector byte. Opcode 0xff with sub-operation 0 increments the operand register and with sub-operation 1 decrements it. None of these changes the flags.
- R6: Opcode 0xf7 with sub-operation 2 inverts the operand register, and with sub-operation 3 negates it. Either sets SF from bit 31 and ZF from zero, and clears OF. Negating 0x80000000 writes nothing and sets SF=1, ZF=0, OF=1.
- R7: Opcode 0xf7 with sub-operation 4 forms the unsigned 64-bit product of register 0 and the operand register. The low half goes to register 0 and the high half to register 2. OF is set exactly when the high half is nonzero, and SF and ZF are kept.
- R8: The sequence 0x0f 0xaf writes the field register with the low 32 bits of the signed product of the field and operand registers. SF and ZF come from that result, and OF is set when the signed product does not fit in 32 bits.
- R9: An unknown first byte, a second byte other than 0xaf after 0x0f, an unsupported sub-operation under 0xf7 or 0xff, or a mode other than 3 gives `illegal` high for one cycle. Registers and flags are unchanged, and the next byte starts a new instruction.
- R10: `done` is high for exactly the one cycle after the edge that takes the last byte of an instruction. Results are visible in that same cycle, and instructions may follow back to back.
- R11: After reset every register and flag is zero and `done` and `illegal` are low.
- R12: `ld_en` writes `ld_val` into register `ld_idx` at the clock edge. `rd_val` shows register `rd_idx` combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction byte present this cycle |
| in_byte | input | 8 | Instruction byte |
| ld_en | input | 1 | Register load strobe |
| ld_idx | input | 3 | Register to load |
| ld_val | input | DW | Value to load |
| rd_idx | input | 3 | Register to observe |
| rd_val | output | DW | Value of register `rd_idx` |
| done | output | 1 | Instruction completed (one cycle) |
| illegal | output | 1 | Encoding rejected (one cycle) |
| flag_s | output | 1 | Sign flag |
| flag_z | output | 1 | Zero flag |
| flag_o | output | 1 | Overflow flag |

## Verification
The hardest states to reach are those that need particular operand values: negating exactly 0x80000000, and a widening multiply whose high half is nonzero. The bench gets there by loading the operands through the load port before it issues the instruction bytes. Rejections partway through an instruction, such as a bad second byte after 0x0f or a bad sub-operation after the group opcode, are sent right after valid instructions with earlier flags still set. A cycle-level reference model then confirms that the flags survive and that the next byte starts a fresh decode.

// File: rtl/rdx_pkg.sv
package rdx_pkg;

    localparam int unsigned NREG = 8;
    localparam int unsigned RIW  = $clog2(NREG);
    localparam logic [RIW-1:0] IDX_ACC = RIW'(0);
    localparam logic [RIW-1:0] IDX_HI  = RIW'(2);
    localparam logic [1:0]     MODE_REG = 2'b11;

    localparam logic [7:0] OPC_ADD   = 8'h01;
    localparam logic [7:0] OPC_SUB   = 8'h29;
    localparam logic [7:0] OPC_AND   = 8'h21;
    localparam logic [7:0] OPC_OR    = 8'h09;
    localparam logic [7:0] OPC_XOR   = 8'h31;
    localparam logic [7:0] OPC_CMP   = 8'h39;
    localparam logic [7:0] OPC_MOV   = 8'h89;
    localparam logic [7:0] OPC_SWAP  = 8'h87;
    localparam logic [7:0] OPC_GRP7  = 8'hf7;
    localparam logic [7:0] OPC_GRPF  = 8'hff;
    localparam logic [7:0] OPC_ESC   = 8'h0f;
    localparam logic [7:0] OPC_SMUL2 = 8'haf;

    typedef enum logic [3:0] {
        OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_CMP, OP_MOV, OP_SWAP,
        OP_INC, OP_DEC, OP_NOT, OP_NEG, OP_MULU, OP_MULS
    } alu_op_e;

    typedef enum logic [1:0] {ST_OPC, ST_EXT, ST_SEL} dec_st_e;

    typedef enum logic [1:0] {PK_FIXED, PK_GRP7, PK_GRPF} pend_e;

    typedef struct packed {
        logic s;
        logic z;
        logic o;
    } flags_t;

    typedef struct packed {
        dec_st_e st;
        pend_e   kind;
        alu_op_e op;
        logic    done;
        logic    ill;
        flags_t  fl;
    } ctl_t;

    typedef struct packed {
        logic    ok;
        pend_e   kind;
        alu_op_e op;
    } first_t;

    function automatic first_t first_lookup(input logic [7:0] b);
        first_t f;
        f.ok   = 1'b1;
        f.kind = PK_FIXED;
        f.op   = OP_MOV;
        case (b)
            OPC_ADD:  f.op = OP_ADD;
            OPC_SUB:  f.op = OP_SUB;
            OPC_AND:  f.op = OP_AND;
            OPC_OR:   f.op = OP_OR;
            OPC_XOR:  f.op = OP_XOR;
            OPC_CMP:  f.op = OP_CMP;
            OPC_MOV:  f.op = OP_MOV;
            OPC_SWAP: f.op = OP_SWAP;
            OPC_GRP7: f.kind = PK_GRP7;
            OPC_GRPF: f.kind = PK_GRPF;
            default:  f.ok = 1'b0;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/rdx_regs.sv
module rdx_regs
    import rdx_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wa_en,
    input  logic [RIW-1:0]            wa_idx,
    input  logic [DW-1:0]             wa_val,
    input  logic                      wb_en,
    input  logic [RIW-1:0]            wb_idx,
    input  logic [DW-1:0]             wb_val,
    input  logic                      ld_en,
    input  logic [RIW-1:0]            ld_idx,
    input  logic [DW-1:0]             ld_val,
    output logic [NREG-1:0][DW-1:0]   regs
);

    // Lane A beats lane B beats the load port on a shared index.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs <= '0;
        end else begin
            for (int i = 0; i < NREG; i++) begin
                if (wa_en && wa_idx == RIW'(i)) begin
                    regs[i] <= wa_val;
                end else if (wb_en && wb_idx == RIW'(i)) begin
                    regs[i] <= wb_val;
                end else if (ld_en && ld_idx == RIW'(i)) begin
                    regs[i] <= ld_val;
                end
            end
        end
    end

endmodule

// File: rtl/rdx_alu.sv
module rdx_alu
    import rdx_pkg::*;
#(
    parameter int DW = 32
) (
    input  alu_op_e       op,
    input  logic [DW-1:0] a,      // operand-field register
    input  logic [DW-1:0] b,      // register-field register
    input  logic [DW-1:0] acc,    // register 0
    input  flags_t        fl_i,
    output logic          wa_en,
    output logic [DW-1:0] wa_val,
    output logic          wb_en,
    output logic [DW-1:0] wb_val,
    output flags_t        fl_o
);

    localparam int MSB = DW - 1;
    localparam logic [DW-1:0] MIN_NEG = {1'b1, {(DW-1){1'b0}}};

    logic [DW-1:0]          sum, dif, neg;
    logic [2*DW-1:0]        pu;
    logic signed [2*DW-1:0] ps;
    logic                   of_add, of_sub, ps_wide;

    always_comb begin
        sum     = a + b;
        dif     = a - b;
        neg     = '0 - a;
        pu      = {{DW{1'b0}}, acc} * {{DW{1'b0}}, a};
        ps      = $signed({{DW{b[MSB]}}, b}) * $signed({{DW{a[MSB]}}, a});
        of_add  = (a[MSB] == b[MSB]) && (sum[MSB] != a[MSB]);
        of_sub  = (a[MSB] != b[MSB]) && (dif[MSB] != a[MSB]);
        ps_wide = ps[2*DW-1:DW] != {DW{ps[MSB]}};
    end

    always_comb begin
        wa_en  = 1'b0;
        wa_val = a;
        wb_en  = 1'b0;
        wb_val = b;
        fl_o   = fl_i;
        unique case (op)
            OP_ADD: begin
                wa_en = 1'b1; wa_val = sum;
                fl_o  = '{s: sum[MSB], z: sum == '0, o: of_add};
            end
            OP_SUB: begin
                wa_en = 1'b1; wa_val = dif;
                fl_o  = '{s: dif[MSB], z: dif == '0, o: of_sub};
            end
            OP_CMP: fl_o = '{s: dif[MSB], z: dif == '0, o: of_sub};
            OP_AND, OP_OR, OP_XOR: begin
                wa_en  = 1'b1;
                wa_val = (op == OP_AND) ? (a & b) : (op == OP_OR) ? (a | b) : (a ^ b);
                fl_o   = '{s: wa_val[MSB], z: wa_val == '0, o: 1'b0};
            end
            OP_MOV: begin
                wa_en = 1'b1; wa_val = b;
            end
            OP_SWAP: begin
                wa_en = 1'b1; wa_val = b;
                wb_en = 1'b1; wb_val = a;
            end
            OP_INC: begin
                wa_en = 1'b1; wa_val = a + DW'(1);
            end
            OP_DEC: begin
                wa_en = 1'b1; wa_val = a - DW'(1);
            end
            OP_NOT: begin
                wa_en = 1'b1; wa_val = ~a;
                fl_o  = '{s: ~a[MSB], z: a == '1, o: 1'b0};
            end
            OP_NEG: begin
                if (a == MIN_NEG) begin
                    fl_o = '{s: 1'b1, z: 1'b0, o: 1'b1};
                end else begin
                    wa_en = 1'b1; wa_val = neg;
                    fl_o  = '{s: neg[MSB], z: neg == '0, o: 1'b0};
                end
            end
            OP_MULU: begin
                wa_en  = 1'b1; wa_val = pu[DW-1:0];
                wb_en  = 1'b1; wb_val = pu[2*DW-1:DW];
                fl_o.o = pu[2*DW-1:DW] != '0;
            end
            OP_MULS: begin
                wb_en = 1'b1; wb_val = ps[DW-1:0];
                fl_o  = '{s: ps[MSB], z: ps[DW-1:0] == '0, o: ps_wide};
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/rdx_exec.sv
module rdx_exec
    import rdx_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [7:0]      in_byte,
    input  logic            ld_en,
    input  logic [2:0]      ld_idx,
    input  logic [DW-1:0]   ld_val,
    input  logic [2:0]      rd_idx,
    output logic [DW-1:0]   rd_val,
    output logic            done,
    output logic            illegal,
    output logic            flag_s,
    output logic            flag_z,
    output logic            flag_o
);

    ctl_t                    q, d;
    first_t                  fst;
    alu_op_e                 x_op;
    logic                    fire, bad, sub_ok;
    logic [RIW-1:0]          f_opd, f_reg, wa_idx, wb_idx;
    logic [NREG-1:0][DW-1:0] regs;
    logic                    wa_en, wb_en, wa_go, wb_go;
    logic [DW-1:0]           wa_val, wb_val;
    flags_t                  alu_fl;

    assign f_opd = in_byte[2:0];
    assign f_reg = in_byte[5:3];
    assign fst   = first_lookup(in_byte);

    // Decide whether this byte completes, and with which operation.
    always_comb begin
        fire   = 1'b0;
        bad    = 1'b0;
        x_op   = q.op;
        sub_ok = 1'b1;
        if (in_valid) begin
            unique case (q.st)
                ST_OPC: begin
                    if (in_byte[7:4] == 4'h4) begin
                        fire = 1'b1;
                        x_op = in_byte[3] ? OP_DEC : OP_INC;
                    end else if (in_byte != OPC_ESC && !fst.ok) begin
                        bad = 1'b1;
                    end
                end
                ST_EXT: bad = (in_byte != OPC_SMUL2);
                ST_SEL: begin
                    unique case (q.kind)
                        PK_GRP7: begin
                            case (f_reg)
                                3'd2:    x_op = OP_NOT;
                                3'd3:    x_op = OP_NEG;
                                3'd4:    x_op = OP_MULU;
                                default: sub_ok = 1'b0;
                            endcase
                        end
                        PK_GRPF: begin
                            case (f_reg)
                                3'd0:    x_op = OP_INC;
                                3'd1:    x_op = OP_DEC;
                                default: sub_ok = 1'b0;
                            endcase
                        end
                        default: x_op = q.op;
                    endcase
                    if (in_byte[7:6] == MODE_REG && sub_ok) begin
                        fire = 1'b1;
                    end else begin
                        bad = 1'b1;
                    end
                end
                default: bad = 1'b0;
            endcase
        end
    end

    assign wa_idx = (x_op == OP_MULU) ? IDX_ACC : f_opd;
    assign wb_idx = (x_op == OP_MULU) ? IDX_HI  : f_reg;
    assign wa_go  = fire && wa_en;
    assign wb_go  = fire && wb_en;

    rdx_alu #(.DW(DW)) u_alu (
        .op     (x_op),
        .a      (regs[f_opd]),
        .b      (regs[f_reg]),
        .acc    (regs[IDX_ACC]),
        .fl_i   (q.fl),
        .wa_en  (wa_en),
        .wa_val (wa_val),
        .wb_en  (wb_en),
        .wb_val (wb_val),
        .fl_o   (alu_fl)
    );

    rdx_regs #(.DW(DW)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wa_en  (wa_go),
        .wa_idx (wa_idx),
        .wa_val (wa_val),
        .wb_en  (wb_go),
        .wb_idx (wb_idx),
        .wb_val (wb_val),
        .ld_en  (ld_en),
        .ld_idx (ld_idx),
        .ld_val (ld_val),
        .regs   (regs)
    );

    // Next control state.
    always_comb begin
        d      = q;
        d.done = fire;
        d.ill  = bad;
        if (in_valid) begin
            unique case (q.st)
                ST_OPC: begin
                    if (in_byte == OPC_ESC) begin
                        d.st = ST_EXT;
                    end else if (in_byte[7:4] != 4'h4 && fst.ok) begin
                        d.st   = ST_SEL;
                        d.kind = fst.kind;
                        d.op   = fst.op;
                    end
                end
                ST_EXT: begin
                    d.st   = bad ? ST_OPC : ST_SEL;
                    d.kind = PK_FIXED;
                    d.op   = OP_MULS;
                end
                default: d.st = ST_OPC;
            endcase
        end
        if (fire) begin
            d.fl = alu_fl;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_OPC, kind: PK_FIXED, op: OP_MOV, done: 1'b0, ill: 1'b0, fl: '0};
        end else begin
            q <= d;
        end
    end

    assign rd_val  = regs[rd_idx];
    assign done    = q.done;
    assign illegal = q.ill;
    assign flag_s  = q.fl.s;
    assign flag_z  = q.fl.z;
    assign flag_o  = q.fl.o;

endmodule

// File: rtl/rdx_exec_chk.sv
module rdx_exec_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic [7:0] in_byte,
    input logic       done,
    input logic       illegal,
    input logic       flag_s,
    input logic       flag_z,
    input logic       flag_o
);

    a_r10_done_needs_byte: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(in_valid));

    a_r9_illegal_needs_byte: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> $past(in_valid));

    a_r9_not_both: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && illegal));

    a_r9_illegal_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> $stable({flag_s, flag_z, flag_o}));

    a_r5_short_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(in_byte[7:4] == 4'h4)) |-> $stable({flag_s, flag_z, flag_o}));

    a_r6_sign_zero_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(flag_s && flag_z));

endmodule

bind rdx_exec rdx_exec_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_byte  (in_byte),
    .done     (done),
    .illegal  (illegal),
    .flag_s   (flag_s),
    .flag_z   (flag_z),
    .flag_o   (flag_o)
);

// File: tb/rdx_exec_tb.sv
`timescale 1ns/1ps
module rdx_exec_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic        ld_en = 1'b0;
    logic [2:0]  ld_idx = 3'd0;
    logic [31:0] ld_val = 32'd0;
    logic [2:0]  rd_idx = 3'd0;
    logic [31:0] rd_val;
    logic        done, illegal, flag_s, flag_z, flag_o;

    int    n_chk = 0;
    int    n_fail = 0;
    string cur_req = "R11";

    always #5 clk = ~clk;

    rdx_exec u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .ld_en(ld_en), .ld_idx(ld_idx), .ld_val(ld_val),
        .rd_idx(rd_idx), .rd_val(rd_val), .done(done), .illegal(illegal),
        .flag_s(flag_s), .flag_z(flag_z), .flag_o(flag_o)
    );

    // ---------------- reference model ----------------
    logic [31:0] m_r [8];
    logic        m_sf, m_zf, m_of, m_done, m_ill;
    int          m_st;
    logic [7:0]  m_opc;
    bit          m_ext;

    task automatic m_flags(input logic [31:0] r, input bit o);
        m_sf = r[31]; m_zf = (r == 32'd0); m_of = o;
    endtask

    task automatic m_exec(input logic [7:0] opc, input bit ext, input logic [7:0] sel);
        logic [2:0]  o = sel[2:0];
        logic [2:0]  g = sel[5:3];
        logic [31:0] a = m_r[o];
        logic [31:0] b = m_r[g];
        logic [31:0] r;
        longint      sx;
        logic [63:0] pu;
        if (sel[7:6] != 2'b11) begin m_ill = 1; return; end
        if (ext) begin
            sx = longint'($signed(b)) * longint'($signed(a));
            r = sx[31:0]; m_r[g] = r;
            m_flags(r, sx != longint'($signed(r)));
            m_done = 1; return;
        end
        case (opc)
            8'h01: begin sx = longint'($signed(a)) + longint'($signed(b)); r = sx[31:0];
                         m_r[o] = r; m_flags(r, sx != longint'($signed(r))); end
            8'h29: begin sx = longint'($signed(a)) - longint'($signed(b)); r = sx[31:0];
                         m_r[o] = r; m_flags(r, sx != longint'($signed(r))); end
            8'h39: begin sx = longint'($signed(a)) - longint'($signed(b)); r = sx[31:0];
                         m_flags(r, sx != longint'($signed(r))); end
            8'h21: begin r = a & b; m_r[o] = r; m_flags(r, 0); end
            8'h09: begin r = a | b; m_r[o] = r; m_flags(r, 0); end
            8'h31: begin r = a ^ b; m_r[o] = r; m_flags(r, 0); end
            8'h89: m_r[o] = b;
            8'h87: begin m_r[g] = a; m_r[o] = b; end
            8'hff: begin
                if (g == 0) m_r[o] = a + 1;
                else if (g == 1) m_r[o] = a - 1;
                else begin m_ill = 1; return; end
            end
            8'hf7: begin
                if (g == 2) begin r = ~a; m_r[o] = r; m_flags(r, 0); end
                else if (g == 3) begin
                    if (a == 32'h8000_0000) begin m_sf = 1; m_zf = 0; m_of = 1; end
                    else begin r = -a; m_r[o] = r; m_flags(r, 0); end
                end else if (g == 4) begin
                    pu = 64'(m_r[0]) * 64'(a);
                    m_r[0] = pu[31:0]; m_r[2] = pu[63:32]; m_of = (pu[63:32] != 0);
                end else begin m_ill = 1; return; end
            end
            default: begin m_ill = 1; return; end
        endcase
        m_done = 1;
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) m_r[i] = 32'd0;
            m_sf = 0; m_zf = 0; m_of = 0; m_done = 0; m_ill = 0;
            m_st = 0; m_opc = 0; m_ext = 0;
        end else begin
            m_done = 0; m_ill = 0;
            if (ld_en) m_r[ld_idx] = ld_val;
            if (in_valid) begin
                if (m_st == 0) begin
                    if (in_byte[7:4] == 4'h4) begin
                        if (in_byte[3]) m_r[in_byte[2:0]] = m_r[in_byte[2:0]] - 1;
                        else            m_r[in_byte[2:0]] = m_r[in_byte[2:0]] + 1;
                        m_done = 1;
                    end else if (in_byte == 8'h0f) m_st = 1;
                    else if (in_byte inside {8'h01, 8'h29, 8'h21, 8'h09, 8'h31, 8'h39,
                                             8'h89, 8'h87, 8'hf7, 8'hff}) begin
                        m_opc = in_byte; m_ext = 0; m_st = 2;
                    end else m_ill = 1;
                end else if (m_st == 1) begin
                    if (in_byte == 8'haf) begin m_ext = 1; m_st = 2; end
                    else begin m_ill = 1; m_st = 0; end
                end else begin
                    m_st = 0;
                    m_exec(m_opc, m_ext, in_byte);
                    m_ext = 0;
                end
            end
        end
    end

    // ---------------- checking ----------------
    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Every cycle: compare all outputs against the model.
    always @(negedge clk) begin
        if (rst_n) begin
            chk({cur_req, " model done"},    32'(done),    32'(m_done));
            chk({cur_req, " model illegal"}, 32'(illegal), 32'(m_ill));
            chk({cur_req, " model flags"},   {29'd0, flag_s, flag_z, flag_o}, {29'd0, m_sf, m_zf, m_of});
            chk({cur_req, " model reg"},     rd_val, m_r[rd_idx]);
        end
    end

    task automatic send(input logic [7:0] b);
        @(posedge clk); #1;
        in_valid = 1'b1; in_byte = b;
    endtask

    task automatic idle();
        @(posedge clk); #1;
        in_valid = 1'b0; in_byte = 8'h00;
    endtask

    task automatic load(input logic [2:0] i, input logic [31:0] v);
        @(posedge clk); #1;
        ld_en = 1'b1; ld_idx = i; ld_val = v;
        @(posedge clk); #1;
        ld_en = 1'b0;
    endtask

    task automatic peek(input string tag, input logic [2:0] i, input logic [31:0] exp);
        @(posedge clk); #1;
        rd_idx = i;
        @(negedge clk);
        chk(tag, rd_val, exp);
    endtask

    task automatic flags(input string tag, input bit s, input bit z, input bit o);
        @(negedge clk);
        chk(tag, {29'd0, flag_s, flag_z, flag_o}, {29'd0, s, z, o});
    endtask

    // Ends the final byte, then checks the one-cycle pulse shape (R10).
    task automatic finish_instr(input string tag, input bit exp_done, input bit exp_ill);
        idle();
        @(negedge clk);
        chk({tag, " done pulse"}, 32'(done), 32'(exp_done));
        chk({tag, " illegal pulse"}, 32'(illegal), 32'(exp_ill));
        @(negedge clk);
        chk({tag, " pulse ends R10"}, 32'(done | illegal), 32'd0);
    endtask

    task automatic ins2(input string tag, input logic [7:0] o, input logic [7:0] s,
                        input bit exp_done);
        cur_req = tag;
        send(o); send(s);
        finish_instr(tag, exp_done, !exp_done);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R11 reset state
        cur_req = "R11";
        for (int i = 0; i < 8; i++) peek("R11 reg zero", 3'(i), 32'd0);
        flags("R11 flags zero", 0, 0, 0);
        chk("R11 no pulse", 32'(done | illegal), 32'd0);

        // R12 load and read
        cur_req = "R12";
        load(3'd0, 32'h0a0b0c0d);
        peek("R12 load EAX", 3'd0, 32'h0a0b0c0d);
        load(3'd3, 32'ha0b0c0d0);
        peek("R12 load reg3", 3'd3, 32'ha0b0c0d0);

        // R2 bitwise and arithmetic (d8: reg=3, operand=0; R1 field split)
        ins2("R2", 8'h09, 8'hd8, 1);
        peek("R2 or result", 3'd0, 32'haabbccdd);
        flags("R2 or flags", 1, 0, 0);
        load(3'd0, 32'h10); load(3'd3, 32'h1);
        ins2("R2", 8'h01, 8'hd8, 1);
        peek("R2 add result", 3'd0, 32'h11);
        flags("R2 add flags", 0, 0, 0);
        load(3'd0, 32'h7fffffff); load(3'd1, 32'h1);
        ins2("R2", 8'h01, 8'hc8, 1);
        peek("R2 add overflow value", 3'd0, 32'h80000000);
        flags("R2 add overflow flags", 1, 0, 1);
        load(3'd0, 32'd10); load(3'd3, 32'd1);
        ins2("R2", 8'h29, 8'hd8, 1);
        peek("R2 sub result", 3'd0, 32'd9);
        load(3'd3, 32'd9);
        ins2("R2", 8'h29, 8'hd8, 1);
        flags("R2 sub zero flags", 0, 1, 0);
        load(3'd0, 32'h0a0b0c0d); load(3'd3, 32'h000000ff);
        ins2("R2", 8'h21, 8'hd8, 1);
        peek("R2 and result", 3'd0, 32'h0000000d);
        load(3'd0, 32'h0a0b0c0d); load(3'd3, 32'haabbc0d0);
        ins2("R2", 8'h31, 8'hd8, 1);
        peek("R2 xor result", 3'd0, 32'ha0b0ccdd);

        // R3 compare
        load(3'd0, 32'h0a0b0c07); load(3'd3, 32'h0a0b0c0d);
        ins2("R3", 8'h39, 8'hd8, 1);
        flags("R3 lesser flags", 1, 0, 0);
        peek("R3 no write", 3'd0, 32'h0a0b0c07);
        load(3'd3, 32'h0a0b0c07);
        ins2("R3", 8'h39, 8'hd8, 1);
        flags("R3 equal flags", 0, 1, 0);
        load(3'd0, 32'h80000000); load(3'd3, 32'h1);
        ins2("R3", 8'h39, 8'hd8, 1);
        flags("R3 overflow flags", 0, 0, 1);

        // R4 move and swap
        load(3'd3, 32'haf); load(3'd0, 32'h2e);
        ins2("R4", 8'h87, 8'hd8, 1);
        peek("R4 swap operand", 3'd0, 32'haf);
        peek("R4 swap field", 3'd3, 32'h2e);
        flags("R4 flags kept", 0, 0, 1);
        ins2("R4", 8'h89, 8'hd8, 1);
        peek("R4 move", 3'd0, 32'h2e);

        // R5 increment / decrement
        load(3'd1, 32'h1f);
        cur_req = "R5"; send(8'h41); finish_instr("R5 short inc", 1, 0);
        peek("R5 short inc value", 3'd1, 32'h20);
        flags("R5 flags kept", 0, 0, 1);
        cur_req = "R5"; send(8'h49); finish_instr("R5 short dec", 1, 0);
        peek("R5 short dec value", 3'd1, 32'h1f);
        load(3'd0, 32'h20);
        ins2("R5", 8'hff, 8'hc0, 1);
        peek("R5 group inc", 3'd0, 32'h21);
        ins2("R5", 8'hff, 8'hc8, 1);
        peek("R5 group dec", 3'd0, 32'h20);

        // R6 not / negate
        load(3'd3, 32'h0f0f00ff);
        ins2("R6", 8'hf7, 8'hd3, 1);
        peek("R6 not", 3'd3, 32'hf0f0ff00);
        flags("R6 not flags", 1, 0, 0);
        load(3'd3, 32'h1);
        ins2("R6", 8'hf7, 8'hdb, 1);
        peek("R6 neg", 3'd3, 32'hffffffff);
        load(3'd3, 32'h80000000);
        ins2("R6", 8'hf7, 8'hdb, 1);
        peek("R6 neg min unchanged", 3'd3, 32'h80000000);
        flags("R6 neg min flags", 1, 0, 1);

        // R7 unsigned widening multiply
        load(3'd0, 32'd4); load(3'd1, 32'd3); load(3'd2, 32'h5555);
        ins2("R7", 8'hf7, 8'he1, 1);
        peek("R7 low", 3'd0, 32'hc);
        peek("R7 high", 3'd2, 32'd0);
        flags("R7 no overflow", 1, 0, 0);
        load(3'd0, 32'h80000000); load(3'd1, 32'd4);
        ins2("R7", 8'hf7, 8'he1, 1);
        peek("R7 wide low", 3'd0, 32'd0);
        peek("R7 wide high", 3'd2, 32'd2);
        flags("R7 overflow", 1, 0, 1);

        // R8 signed multiply into field register
        load(3'd0, 32'd4); load(3'd3, 32'd2);
        cur_req = "R8"; send(8'h0f); send(8'haf); send(8'hd8);
        finish_instr("R8", 1, 0);
        peek("R8 product", 3'd3, 32'd8);
        load(3'd0, 32'd5); load(3'd3, -32'sd3);
        cur_req = "R8"; send(8'h0f); send(8'haf); send(8'hd8);
        finish_instr("R8 negative", 1, 0);
        peek("R8 negative product", 3'd3, -32'sd15);
        flags("R8 negative flags", 1, 0, 0);

        // R9 illegal encodings
        load(3'd0, 32'h1234);
        cur_req = "R9"; send(8'h00); finish_instr("R9 unknown opcode", 0, 1);
        ins2("R9", 8'h01, 8'h18, 0);
        peek("R9 memory mode no write", 3'd0, 32'h1234);
        ins2("R9", 8'hf7, 8'hc0, 0);
        ins2("R9", 8'hff, 8'hd0, 0);
        cur_req = "R9"; send(8'h0f); send(8'h00); finish_instr("R9 bad escape", 0, 1);
        flags("R9 flags kept", 1, 0, 0);
        cur_req = "R9"; send(8'h0f); send(8'h40); finish_instr("R9 restart", 0, 1);
        peek("R9 escape byte not executed", 3'd0, 32'h1234);

        // R10 back-to-back short instructions
        cur_req = "R10";
        send(8'h40);
        send(8'h40);
        @(negedge clk); chk("R10 first done", 32'(done), 32'd1);
        send(8'h40);
        @(negedge clk); chk("R10 second done", 32'(done), 32'd1);
        finish_instr("R10 third", 1, 0);
        peek("R10 three increments", 3'd0, 32'h1237);

        repeat (3) @(posedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule